// File: doc/BRIEF.md
# BCD Digital Clock Time Counter

This block keeps the time of day as six BCD digits (hours, minutes and seconds, each a tens and a units digit) for a six-digit clock display. It divides the system clock down to a one-second tick. Seconds and minutes are each a mod-10 units digit whose carry steps a mod-6 tens digit. The minutes carry steps the hours, which run from 00 to 23.

After reset the block waits in set mode. In set mode, single-cycle increment pulses step the field chosen by a select input, and the tick is not generated. A start pulse leaves set mode and timekeeping begins. Raising the set-mode select at any time returns the block to set mode and freezes the time. Each time the running clock reaches a full hour, a chime output goes high for exactly one second. The `TICK_DIV` parameter sets the number of system clock cycles in one second, so a short value can be used in simulation.

Top module: `bcd_clock_core`

## Requirements
- R1: While reset is asserted and after it is released, all six digits read 0 (00:00:00), the chime output is low and the block is in set mode, so the time does not advance until a start pulse arrives.
- R2: In set mode an increment pulse steps one field. The field is chosen by the select input: 0 is seconds, 1 is minutes, 2 is hours, and 3 changes nothing. Seconds and minutes wrap from 59 to 00, hours wrap from 23 to 00, and a wrap never carries into another field.
- R3: A start pulse in set mode enters run mode. The seconds first advance TICK_DIV clock cycles after the start edge, then once every TICK_DIV cycles.
- R4: The seconds units digit counts 0 to 9 and its carry steps the seconds tens digit 0 to 5. On the edge where the time leaves second 59, the seconds become 00 and the minutes advance.
- R5: Minutes use the same cascade. On the edge where the time leaves minute 59 second 59, the minutes become 00 and the hours advance.
- R6: Hours run 00 to 23, and the running clock wraps from 23:59:59 to 00:00:00.
- R7: On the clock edge where the running time enters a full hour (minutes and seconds 00), the chime output goes high and stays high for exactly TICK_DIV cycles. Wrapping a field in set mode never raises the chime.
- R8: A high set-mode select returns the block to set mode on the next edge and overrides a start pulse in the same cycle. If a tick falls in that same cycle, it still advances the time. In set mode the time holds, and increment pulses have no effect while running.
- R9: Each units digit stays within 0 to 9, each seconds and minutes tens digit within 0 to 5, and the hours never exceed 23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| set_mode_i | input | 1 | Enter set mode and stop timekeeping |
| field_sel_i | input | 2 | Field stepped by increment: 0 seconds, 1 minutes, 2 hours, 3 none |
| inc_i | input | 1 | Single-cycle increment pulse, used in set mode only |
| start_i | input | 1 | Single-cycle start pulse, leaves set mode |
| sec_ones_o | output | 4 | Seconds units digit |
| sec_tens_o | output | 4 | Seconds tens digit |
| min_ones_o | output | 4 | Minutes units digit |
| min_tens_o | output | 4 | Minutes tens digit |
| hr_ones_o | output | 4 | Hours units digit |
| hr_tens_o | output | 4 | Hours tens digit |
| chime_o | output | 1 | High for one second from each full hour |

## Verification
The collision that matters is a tick that carries the clock into a new hour arriving in the same cycle as a request to return to set mode. The bench loads 01:59:59, starts the clock and follows the divider phase in its own model. It raises the set-mode select exactly in the cycle that holds the tick. It then expects the time to read 02:00:00, the chime to run its full TICK_DIV cycles, and the time to stay frozen even after the divider period has passed. A start pulse given together with the set-mode select is also applied, and the time must stay frozen.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;
  localparam int NUM_FIELDS = 3;

  typedef logic [3:0] bcd_t;

  typedef enum logic {
    MODE_SET = 1'b0,
    MODE_RUN = 1'b1
  } mode_e;

  // Highest tens digit of a field: hours stop at 2, the others at 5.
  function automatic bcd_t field_top_tens(input int f);
    return (f == NUM_FIELDS - 1) ? 4'd2 : 4'd5;
  endfunction

  // Units digit paired with the highest tens digit before the wrap.
  function automatic bcd_t field_top_units(input int f);
    return (f == NUM_FIELDS - 1) ? 4'd3 : 4'd9;
  endfunction
endpackage

// File: rtl/bcd_clock_tick.sv
module bcd_clock_tick #(
  parameter int unsigned DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run_i)             cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  if (DIV > 1) begin : g_chk
    // First cycle of running never carries a tick: full second after start.
    assert_first_second_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_i) |-> !tick_o);
    assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/bcd_clock_pair.sv
module bcd_clock_pair
  import bcd_clock_pkg::*;
#(
  parameter bcd_t TOP_TENS  = 4'd5,
  parameter bcd_t TOP_UNITS = 4'd9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output bcd_t ones_o,
  output bcd_t tens_o,
  output logic carry_o
);
  bcd_t ones_q, ones_d, tens_q, tens_d;
  logic at_top;

  assign at_top  = (ones_q == TOP_UNITS) && (tens_q == TOP_TENS);
  assign carry_o = step_i && at_top;

  always_comb begin
    ones_d = ones_q;
    tens_d = tens_q;
    if (step_i) begin
      if (at_top) begin
        ones_d = '0;
        tens_d = '0;
      end else if (ones_q == 4'd9) begin
        ones_d = '0;
        tens_d = tens_q + 4'd1;
      end else begin
        ones_d = ones_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      tens_q <= '0;
    end else if (step_i) begin
      ones_q <= ones_d;
      tens_q <= tens_d;
    end
  end

  assign ones_o = ones_q;
  assign tens_o = tens_q;

  assert_digit_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_o <= 4'd9) && (tens_o <= TOP_TENS) &&
    !((tens_o == TOP_TENS) && (ones_o > TOP_UNITS)));
  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |=> (ones_o == 4'd0) && (tens_o == 4'd0));
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(ones_o) && $stable(tens_o));
endmodule

// File: rtl/bcd_clock_chime.sv
module bcd_clock_chime #(
  parameter int unsigned DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hour_i,
  output logic chime_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic on_q, on_d;

  always_comb begin
    on_d  = on_q;
    cnt_d = cnt_q;
    if (hour_i) begin
      on_d  = 1'b1;
      cnt_d = '0;
    end else if (on_q) begin
      if (cnt_q == LAST) on_d  = 1'b0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      on_q  <= on_d;
      cnt_q <= cnt_d;
    end
  end

  assign chime_o = on_q;

  assert_chime_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hour_i |=> chime_o);
endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core
  import bcd_clock_pkg::*;
#(
  parameter int unsigned TICK_DIV = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_mode_i,
  input  logic [1:0] field_sel_i,
  input  logic       inc_i,
  input  logic       start_i,
  output logic [3:0] sec_ones_o,
  output logic [3:0] sec_tens_o,
  output logic [3:0] min_ones_o,
  output logic [3:0] min_tens_o,
  output logic [3:0] hr_ones_o,
  output logic [3:0] hr_tens_o,
  output logic       chime_o
);
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  mode_e mode_q, mode_d;
  logic  run, tick;

  always_comb begin
    mode_d = mode_q;
    if (set_mode_i)                          mode_d = MODE_SET;
    else if (mode_q == MODE_SET && start_i)  mode_d = MODE_RUN;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) mode_q <= MODE_SET;
    else             mode_q <= mode_d;
  end

  assign run = (mode_q == MODE_RUN);

  bcd_clock_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_core_n), .run_i(run), .tick_o(tick)
  );

  logic [NUM_FIELDS-1:0] step, carry;
  bcd_t ones [NUM_FIELDS];
  bcd_t tens [NUM_FIELDS];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    logic chain_in;
    if (g == 0) begin : g_first
      assign chain_in = tick;
    end else begin : g_next
      assign chain_in = carry[g-1];
    end
    assign step[g] = run ? chain_in : (inc_i && (field_sel_i == 2'(g)));

    bcd_clock_pair #(
      .TOP_TENS (field_top_tens(g)),
      .TOP_UNITS(field_top_units(g))
    ) u_pair (
      .clk(clk), .rst_n(rst_core_n), .step_i(step[g]),
      .ones_o(ones[g]), .tens_o(tens[g]), .carry_o(carry[g])
    );
  end

  bcd_clock_chime #(.DIV(TICK_DIV)) u_chime (
    .clk(clk), .rst_n(rst_core_n), .hour_i(run && carry[1]), .chime_o(chime_o)
  );

  assign sec_ones_o = ones[0];
  assign sec_tens_o = tens[0];
  assign min_ones_o = ones[1];
  assign min_tens_o = tens[1];
  assign hr_ones_o  = ones[2];
  assign hr_tens_o  = tens[2];

  assert_start_enters_run_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_q == MODE_SET) && start_i && !set_mode_i |=> run);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    set_mode_i |=> !run);
  assert_no_chime_in_set_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    !run |=> !$rose(chime_o));
endmodule

// File: tb/bcd_clock_core_tb_top.sv
module bcd_clock_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n, set_mode, inc, start;
  logic [1:0] sel;
  logic [3:0] so, st, mo, mt, ho, ht;
  logic chime;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_clock_core #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .set_mode_i(set_mode), .field_sel_i(sel),
    .inc_i(inc), .start_i(start),
    .sec_ones_o(so), .sec_tens_o(st), .min_ones_o(mo), .min_tens_o(mt),
    .hr_ones_o(ho), .hr_tens_o(ht), .chime_o(chime)
  );

  int m_h, m_m, m_s, m_pre, m_chime;
  bit m_set;
  int vectors = 0, errors = 0;
  string req = "R1";

  function automatic logic [24:0] pack(int h, int m, int s, bit c);
    return {4'(h/10), 4'(h%10), 4'(m/10), 4'(m%10), 4'(s/10), 4'(s%10), c};
  endfunction

  task automatic check_out();
    logic [24:0] act, exp_v;
    act   = {ht, ho, mt, mo, st, so, chime};
    exp_v = pack(m_h, m_m, m_s, m_chime > 0);
    vectors++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s time/chime act %h exp %h at %0t", req, act, exp_v, $time);
    end
    if (so > 9 || mo > 9 || ho > 9 || st > 5 || mt > 5 || ht > 2 || (ht == 2 && ho > 3)) begin
      errors++;
      $display("FAIL R9 digit range act %h exp legal BCD", act);
    end
  endtask

  task automatic model_step(bit sm, logic [1:0] fs, bit in, bit stt);
    bit old_set = m_set;
    bit hr = 1'b0;
    if (old_set) begin
      m_pre = 0;
      if (in) case (fs)
        2'd0: m_s = (m_s + 1) % 60;
        2'd1: m_m = (m_m + 1) % 60;
        2'd2: m_h = (m_h + 1) % 24;
        default: ;
      endcase
    end else if (m_pre == DIV - 1) begin
      m_pre = 0;
      m_s++;
      if (m_s == 60) begin
        m_s = 0; m_m++;
        if (m_m == 60) begin m_m = 0; m_h = (m_h + 1) % 24; hr = 1'b1; end
      end
    end else begin
      m_pre++;
    end
    if (hr) m_chime = DIV;
    else if (m_chime > 0) m_chime--;
    if (sm) m_set = 1'b1;
    else if (old_set && stt) m_set = 1'b0;
  endtask

  task automatic cyc(bit sm, logic [1:0] fs, bit in, bit stt);
    set_mode = sm; sel = fs; inc = in; start = stt;
    @(posedge clk);
    model_step(sm, fs, in, stt);
    @(negedge clk);
    check_out();
  endtask

  task automatic set_time(int h, int m, int s);
    cyc(1'b1, 2'd3, 1'b0, 1'b0);
    for (int i = (s - m_s + 60) % 60; i > 0; i--) cyc(1'b0, 2'd0, 1'b1, 1'b0);
    for (int i = (m - m_m + 60) % 60; i > 0; i--) cyc(1'b0, 2'd1, 1'b1, 1'b0);
    for (int i = (h - m_h + 24) % 24; i > 0; i--) cyc(1'b0, 2'd2, 1'b1, 1'b0);
  endtask

  task automatic run_noisy(int n);
    for (int i = 0; i < n; i++)
      cyc(1'b0, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'b0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog act running exp finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'hC10C));
    rst_n = 1'b0; set_mode = 1'b0; sel = 2'd0; inc = 1'b0; start = 1'b0;
    m_h = 0; m_m = 0; m_s = 0; m_pre = 0; m_chime = 0; m_set = 1'b1;
    repeat (3) @(negedge clk);
    req = "R1"; check_out();
    rst_n = 1'b1;
    for (int i = 0; i < 3 * DIV; i++) cyc(1'b0, 2'd0, 1'b0, 1'b0);

    // R2: random field steps, including select 3, in set mode
    req = "R2";
    for (int i = 0; i < 400; i++)
      cyc(1'b0, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'b0);
    set_time(23, 59, 59);
    cyc(1'b0, 2'd0, 1'b1, 1'b0);
    cyc(1'b0, 2'd1, 1'b1, 1'b0);
    cyc(1'b0, 2'd2, 1'b1, 1'b0);
    req = "R7"; set_time(5, 59, 0); cyc(1'b0, 2'd1, 1'b1, 1'b0);

    // R3 first second length, R4 seconds cascade with ignored increments
    req = "R3"; set_time(0, 0, 0);
    cyc(1'b0, 2'd0, 1'b0, 1'b1);
    for (int i = 0; i < 3 * DIV; i++) cyc(1'b0, 2'd0, 1'b0, 1'b0);
    req = "R4"; run_noisy(70 * DIV);

    // R8: freeze, start overridden by set-mode select
    req = "R8";
    cyc(1'b1, 2'd0, 1'b0, 1'b0);
    cyc(1'b1, 2'd0, 1'b0, 1'b1);
    for (int i = 0; i < 3 * DIV; i++) cyc(1'b0, 2'd3, 1'b1, 1'b0);

    req = "R5"; set_time(0, 58, 50);
    cyc(1'b0, 2'd0, 1'b0, 1'b1);
    run_noisy(15 * DIV);
    req = "R6"; set_time(23, 59, 55);
    cyc(1'b0, 2'd0, 1'b0, 1'b1);
    run_noisy(12 * DIV);

    // Collision: hour-carrying tick together with set-mode select (R7, R8)
    req = "R7"; set_time(1, 59, 59);
    cyc(1'b0, 2'd0, 1'b0, 1'b1);
    while (m_pre != DIV - 1) cyc(1'b0, 2'd0, 1'b0, 1'b0);
    cyc(1'b1, 2'd0, 1'b0, 1'b0);
    for (int i = 0; i < 3 * DIV; i++) cyc(1'b0, 2'd3, 1'b0, 1'b0);

    // Mixed random control traffic
    req = "R8";
    for (int i = 0; i < 6000; i++)
      cyc(1'($urandom_range(0, 199) == 0), 2'($urandom_range(0, 3)),
          1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 49) == 0));

    summary();
    $finish;
  end
endmodule